// File: doc/BRIEF.md
# Audio Clock Generator

This block produces the three clocks shared by the receive and transmit paths of a serial audio port. From a fast system clock it derives an oversampling master clock, a bit clock and a per-frame strobe. The frame strobe is either a half-frame word select for two-channel links or a one-bit frame sync for time-division multiplexed links. All three come from one chain of counters, so they keep a fixed phase relationship to each other. Every output is a registered copy of the counter state, so the outputs are free of glitches.

The clocks are produced only when the port drives the link (master or controller). In slave mode the outputs stay low and the link clocks come from outside. The master clock ratio, the divider from the system clock, the slot count, the slot width and the strobe style are set on input pins. A setting that cannot be realised is flagged and blocks start. A setting that is accepted is frozen when the clocks start. Starting and stopping happen only at frame boundaries, so the outputs never carry a shortened pulse.

Top module: `audio_clock_gen`

## Requirements
- R1: After reset, and whenever the generator is idle, `mclkOut`, `bclkOut` and `frameOut` are low and `cfgError` is low until the first clock edge after reset.
- R2: While running, `mclkOut` is low for the first `mclkDiv` system clock cycles of a frame and then toggles every `mclkDiv` cycles. A frame lasts `mclkRatio` master clock periods, which is 2·`mclkDiv`·`mclkRatio` system cycles.
- R3: Each bit clock half lasts Q master clock halves, where Q = `mclkRatio` / F and F is the number of bits per frame. `bclkOut` is low in the first half of each bit, and every bit clock edge coincides with a master clock edge.
- R4: F is the slot count times `slotBits`. When `tdmMode` = 0 the slot count is fixed at 2, and `frameOut` is low for bits 0 to F/2−1 and high for the remaining bits.
- R5: When `tdmMode` = 1, the slot count is `slotCountM1` + 1 (1 to 8), and `frameOut` is high only during bit 0 of each frame (one bit clock period).
- R6: A setting is valid when 16 ≤ `mclkRatio` ≤ 1024, `slotBits` ≠ 0, `mclkDiv` ≠ 0 and `mclkRatio` is an exact multiple of F. `cfgError` shows the inverse of this for the inputs seen at the previous clock edge, and the clocks never start while the setting is invalid.
- R7: `modeSel` encodes 0 = slave, 1 = master, 2 = controller and 3 = reserved. A start needs `clkEn` high, mode 1 or 2 and a valid setting. When all three hold at a clock edge, the outputs show frame position 0 from that edge on (frame sync high in TDM, everything else low).
- R8: If `clkEn` drops, or the mode leaves master/controller, while running, the current frame completes in full. The outputs go low at the edge that would have started the next frame.
- R9: Changes to the setting inputs while running have no effect on the outputs until the generator has stopped and started again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock that all outputs are derived from |
| rstN | input | 1 | Asynchronous reset, active low |
| clkEn | input | 1 | Request to run the clocks |
| modeSel | input | 2 | Port role: 0 slave, 1 master, 2 controller, 3 reserved |
| tdmMode | input | 1 | 0 = two-slot word select, 1 = multi-slot frame sync |
| slotCountM1 | input | 3 | Slot count minus one (TDM only) |
| slotBits | input | 6 | Bit clocks per slot |
| mclkRatio | input | 11 | Master clock periods per frame (16 to 1024) |
| mclkDiv | input | 8 | System clock cycles per master clock half period |
| mclkOut | output | 1 | Oversampling master clock |
| bclkOut | output | 1 | Bit clock |
| frameOut | output | 1 | Word select or frame sync strobe |
| cfgError | output | 1 | Setting inputs cannot be realised |

## Verification
The assertions assume that the divider, ratio and frame fields are used only through the frozen copy while the generator runs. They also assume that reset is held from time zero, so every history they look at begins in the idle state. The stimulus changes inputs only at falling edges of the system clock, and the reference model samples them at the rising edge, as the design does. The settings it applies while running are deliberately different from the frozen ones. This shows at the outputs that such changes are ignored and keeps the counter-range checks meaningful. The invalid settings tried cover each rule on its own: a ratio that is not a multiple of the frame, a ratio too small, a ratio too large, a zero divider and a zero slot width.

// File: rtl/aclk_pkg.sv
package aclk_pkg;

  localparam int RATIO_W   = 11;
  localparam int DIV_W     = 8;
  localparam int WIDTH_W   = 6;
  localparam int SLOT_W    = 3;
  localparam int MIN_RATIO = 16;
  localparam int MAX_RATIO = 1024;

  localparam int BITS_W = WIDTH_W + SLOT_W + 1;
  localparam int QUOT_W = (RATIO_W > BITS_W) ? RATIO_W : BITS_W;

  localparam logic [1:0] MODE_SLAVE  = 2'd0;
  localparam logic [1:0] MODE_MASTER = 2'd1;
  localparam logic [1:0] MODE_CTRL   = 2'd2;

  typedef struct packed {
    logic [DIV_W-1:0]   div;
    logic [RATIO_W-1:0] perBit;
    logic [BITS_W-1:0]  frameBits;
    logic               tdm;
  } aclk_cfg_t;

  typedef struct packed {
    logic active;
    logic advance;
  } aclk_strobe_t;

  typedef enum logic {ST_IDLE, ST_RUN} aclk_state_t;

endpackage

// File: rtl/aclk_ctrl.sv
module aclk_ctrl
  import aclk_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                clkEn,
  input  logic [1:0]          modeSel,
  input  logic                tdmMode,
  input  logic [SLOT_W-1:0]   slotCountM1,
  input  logic [WIDTH_W-1:0]  slotBits,
  input  logic [RATIO_W-1:0]  mclkRatio,
  input  logic [DIV_W-1:0]    mclkDiv,
  input  logic                frameEnd,
  output aclk_strobe_t        strobe,
  output aclk_cfg_t           cfgUse,
  output logic                cfgError
);

  aclk_state_t state, stateNext;
  aclk_cfg_t   liveCfg, shadowCfg;

  logic [SLOT_W:0]   slotsEff;
  logic [BITS_W-1:0] frameBitsLive;
  logic [QUOT_W-1:0] ratioExt, bitsSafe, quotient, remainder;
  logic              ratioInRange, cfgOkLive, modeOk, startReq, keepReq;

  always_comb begin
    slotsEff      = tdmMode ? ({1'b0, slotCountM1} + 1'b1) : (SLOT_W+1)'(2);
    frameBitsLive = BITS_W'(slotsEff) * BITS_W'(slotBits);
    ratioExt      = QUOT_W'(mclkRatio);
    bitsSafe      = (frameBitsLive == '0) ? QUOT_W'(1) : QUOT_W'(frameBitsLive);
    quotient      = ratioExt / bitsSafe;
    remainder     = ratioExt % bitsSafe;
    ratioInRange  = (ratioExt >= QUOT_W'(MIN_RATIO)) && (ratioExt <= QUOT_W'(MAX_RATIO));
    cfgOkLive     = ratioInRange && (slotBits != '0) && (mclkDiv != '0) && (remainder == '0);
    modeOk        = (modeSel == MODE_MASTER) || (modeSel == MODE_CTRL);
    startReq      = clkEn && modeOk && cfgOkLive;
    keepReq       = clkEn && modeOk;

    liveCfg.div       = mclkDiv;
    liveCfg.perBit    = RATIO_W'(quotient);
    liveCfg.frameBits = frameBitsLive;
    liveCfg.tdm       = tdmMode;
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE: if (startReq) stateNext = ST_RUN;
      ST_RUN:  if (frameEnd && !keepReq) stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
    strobe.active  = (stateNext == ST_RUN);
    strobe.advance = (state == ST_RUN);
    cfgUse         = (state == ST_RUN) ? shadowCfg : liveCfg;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      shadowCfg <= '0;
      cfgError  <= 1'b0;
    end else begin
      state    <= stateNext;
      cfgError <= !cfgOkLive;
      if (state == ST_IDLE) shadowCfg <= liveCfg;
    end
  end

  AST_STOP_ON_FRAME_END: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE) && $past(state == ST_RUN) |-> $past(frameEnd)); // R8

  AST_START_CFG_CLEAN: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN) && $past(state == ST_IDLE) |-> !cfgError); // R6

endmodule

// File: rtl/aclk_datapath.sv
module aclk_datapath
  import aclk_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  aclk_strobe_t strobe,
  input  aclk_cfg_t    cfg,
  output logic         mclkOut,
  output logic         bclkOut,
  output logic         frameOut,
  output logic         frameEnd
);

  logic [DIV_W-1:0]   divCnt, divNext;
  logic [RATIO_W-1:0] halfCnt, halfNext;
  logic [BITS_W-1:0]  bitCnt, bitNext;
  logic               bitPhase, phaseNext;
  logic               mclkQ, mclkNext, bclkQ, frameQ, frameNext, activeQ;
  logic               divWrap, halfWrap, bitWrap;

  always_comb begin
    divWrap  = (divCnt == DIV_W'(cfg.div - 1'b1));
    halfWrap = divWrap && (halfCnt == RATIO_W'(cfg.perBit - 1'b1));
    bitWrap  = halfWrap && bitPhase;
    frameEnd = bitWrap && (bitCnt == BITS_W'(cfg.frameBits - 1'b1));
  end

  always_comb begin
    divNext   = '0;
    halfNext  = '0;
    bitNext   = '0;
    phaseNext = 1'b0;
    mclkNext  = 1'b0;
    if (strobe.active && strobe.advance) begin
      divNext   = divWrap ? '0 : divCnt + 1'b1;
      mclkNext  = divWrap ? !mclkQ : mclkQ;
      halfNext  = halfWrap ? '0 : (divWrap ? halfCnt + 1'b1 : halfCnt);
      phaseNext = halfWrap ? !bitPhase : bitPhase;
      bitNext   = bitWrap ? (frameEnd ? '0 : bitCnt + 1'b1) : bitCnt;
    end
    if (!strobe.active)
      frameNext = 1'b0;
    else if (cfg.tdm)
      frameNext = (bitNext == '0);
    else
      frameNext = (bitNext >= (cfg.frameBits >> 1));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt   <= '0;
      halfCnt  <= '0;
      bitCnt   <= '0;
      bitPhase <= 1'b0;
      mclkQ    <= 1'b0;
      bclkQ    <= 1'b0;
      frameQ   <= 1'b0;
      activeQ  <= 1'b0;
    end else begin
      divCnt   <= divNext;
      halfCnt  <= halfNext;
      bitCnt   <= bitNext;
      bitPhase <= phaseNext;
      mclkQ    <= mclkNext;
      bclkQ    <= phaseNext;
      frameQ   <= frameNext;
      activeQ  <= strobe.active;
    end
  end

  assign mclkOut  = mclkQ;
  assign bclkOut  = bclkQ;
  assign frameOut = frameQ;

  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !activeQ |-> !mclkQ && !bclkQ && !frameQ); // R1

  AST_DIV_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    activeQ && strobe.advance |-> divCnt < cfg.div); // R2

  AST_BCLK_ON_MCLK_EDGE: assert property (@(posedge clk) disable iff (!rstN)
    activeQ && $past(activeQ) && (bclkQ != $past(bclkQ)) |-> mclkQ != $past(mclkQ)); // R3

  AST_STROBE_ON_BCLK_FALL: assert property (@(posedge clk) disable iff (!rstN)
    activeQ && $past(activeQ) && (frameQ != $past(frameQ)) |-> $past(bclkQ) && !bclkQ); // R4

  AST_SYNC_AFTER_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    frameEnd && strobe.advance && cfg.tdm |=> frameOut || !activeQ); // R5

endmodule

// File: rtl/audio_clock_gen.sv
module audio_clock_gen
  import aclk_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               clkEn,
  input  logic [1:0]         modeSel,
  input  logic               tdmMode,
  input  logic [SLOT_W-1:0]  slotCountM1,
  input  logic [WIDTH_W-1:0] slotBits,
  input  logic [RATIO_W-1:0] mclkRatio,
  input  logic [DIV_W-1:0]   mclkDiv,
  output logic               mclkOut,
  output logic               bclkOut,
  output logic               frameOut,
  output logic               cfgError
);

  aclk_strobe_t strobe;
  aclk_cfg_t    cfgUse;
  logic         frameEnd;

  aclk_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .clkEn       (clkEn),
    .modeSel     (modeSel),
    .tdmMode     (tdmMode),
    .slotCountM1 (slotCountM1),
    .slotBits    (slotBits),
    .mclkRatio   (mclkRatio),
    .mclkDiv     (mclkDiv),
    .frameEnd    (frameEnd),
    .strobe      (strobe),
    .cfgUse      (cfgUse),
    .cfgError    (cfgError)
  );

  aclk_datapath u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .cfg      (cfgUse),
    .mclkOut  (mclkOut),
    .bclkOut  (bclkOut),
    .frameOut (frameOut),
    .frameEnd (frameEnd)
  );

endmodule

// File: tb/audio_clock_gen_test.sv
module audio_clock_gen_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        clkEn = 1'b0;
  logic [1:0]  modeSel = 2'd0;
  logic        tdmMode = 1'b0;
  logic [2:0]  slotCountM1 = 3'd0;
  logic [5:0]  slotBits = 6'd0;
  logic [10:0] mclkRatio = 11'd0;
  logic [7:0]  mclkDiv = 8'd0;
  logic        mclkOut, bclkOut, frameOut, cfgError;

  int checks = 0;
  int failures = 0;
  bit finished = 0;
  string curTag = "R1";

  int mRun = 0, mT = 0, mH = 1, mQ = 1, mB = 1, mTdm = 0;
  bit expErr = 0;

  always #2 clk = !clk;

  audio_clock_gen uut (
    .clk(clk), .rstN(rstN), .clkEn(clkEn), .modeSel(modeSel), .tdmMode(tdmMode),
    .slotCountM1(slotCountM1), .slotBits(slotBits), .mclkRatio(mclkRatio),
    .mclkDiv(mclkDiv), .mclkOut(mclkOut), .bclkOut(bclkOut), .frameOut(frameOut),
    .cfgError(cfgError)
  );

  function automatic int frameBitsNow();
    return (tdmMode ? int'(slotCountM1) + 1 : 2) * int'(slotBits);
  endfunction

  function automatic bit cfgValid();
    int b = frameBitsNow();
    int r = int'(mclkRatio);
    if (b == 0 || mclkDiv == 0 || r < 16 || r > 1024) return 0;
    return (r % b) == 0;
  endfunction

  task automatic modelEdge();
    bit ok, keep;
    if (!rstN) begin
      mRun = 0; mT = 0; expErr = 0;
      return;
    end
    ok   = cfgValid();
    keep = clkEn && (modeSel == 2'd1 || modeSel == 2'd2);
    if (mRun == 0) begin
      if (keep && ok) begin
        mRun = 1; mT = 0;
        mB = frameBitsNow(); mQ = int'(mclkRatio) / mB; mH = int'(mclkDiv); mTdm = tdmMode;
      end
    end else if (mT == 2 * mH * mQ * mB - 1) begin
      mT = 0;
      if (!keep) mRun = 0;
    end else begin
      mT++;
    end
    expErr = !ok;
  endtask

  task automatic checkBit(string name, logic got, bit exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s %s got %b exp %0b at %0t", curTag, name, got, exp, $time);
    end
  endtask

  task automatic compare();
    bit eM = 0, eB = 0, eF = 0;
    int bitIdx;
    if (mRun != 0) begin
      eM = ((mT / mH) % 2) == 1;
      eB = ((mT / (mH * mQ)) % 2) == 1;
      bitIdx = mT / (2 * mH * mQ);
      eF = mTdm ? (bitIdx == 0) : (bitIdx >= mB / 2);
    end
    checkBit("mclkOut", mclkOut, eM);
    checkBit("bclkOut", bclkOut, eB);
    checkBit("frameOut", frameOut, eF);
    checkBit("cfgError", cfgError, expErr);
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      modelEdge();
      @(negedge clk);
      compare();
    end
  endtask

  task automatic setCfg(bit tdm, int slotsM1, int width, int ratio, int div);
    tdmMode = tdm; slotCountM1 = 3'(slotsM1); slotBits = 6'(width);
    mclkRatio = 11'(ratio); mclkDiv = 8'(div);
  endtask

  initial begin
    int cyc = 0;
    while (!finished) begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000 && !finished) begin
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    curTag = "R1";
    run(5);
    rstN = 1'b1;
    run(5);

    curTag = "R6";
    modeSel = 2'd1; clkEn = 1'b1;
    setCfg(0, 0, 16, 48, 1);  run(30);
    setCfg(0, 0, 4, 8, 1);    run(10);
    setCfg(0, 0, 8, 1040, 1); run(10);
    setCfg(0, 0, 8, 64, 0);   run(10);
    setCfg(0, 0, 0, 64, 1);   run(10);

    curTag = "R2_R3_R4";
    setCfg(0, 0, 8, 32, 1);   run(200);

    curTag = "R9";
    setCfg(0, 0, 16, 64, 2);  run(100);
    setCfg(0, 0, 8, 32, 1);

    curTag = "R8";
    clkEn = 1'b0;             run(150);

    curTag = "R5";
    setCfg(1, 3, 8, 64, 2);
    clkEn = 1'b1;             run(600);

    curTag = "R8";
    modeSel = 2'd0;           run(300);

    curTag = "R7";
    modeSel = 2'd3;           run(50);
    modeSel = 2'd0;           run(50);
    modeSel = 2'd2;           run(300);

    curTag = "R3";
    clkEn = 1'b0;             run(300);
    setCfg(0, 0, 8, 48, 3);
    clkEn = 1'b1;             run(700);

    curTag = "R5";
    clkEn = 1'b0;             run(700);
    setCfg(1, 7, 24, 192, 1);
    clkEn = 1'b1;             run(500);

    curTag = "R2";
    clkEn = 1'b0;             run(500);
    setCfg(0, 0, 32, 1024, 1);
    clkEn = 1'b1;             run(2200);
    clkEn = 1'b0;             run(2100);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule